// File: doc/BRIEF.md
# Byte-to-burst memory word bridge

This bridge sits between an 8-bit CPU bus and a memory driver that stores 32-bit words as pairs of 16-bit half-words. Each CPU byte access becomes a word access. The upper CPU address bits choose the word and the lowest two bits choose a byte lane within it. The bridge builds the half-word address for the driver and puts the returned beats back together into a 32-bit word. It then returns the addressed byte, or merges a new byte into the word and writes the word back.

In a two-beat burst, the low bit of the start address sets the order in which the two half-words arrive. The bridge always clears that bit in burst mode, so the first beat is always the low half-word. A configuration input selects single-beat operation instead. In that mode each half-word is a separate request, first at the even half-word address and then at the odd one.

The CPU side is a pulse-request / ready handshake that stalls a slow CPU until the access is complete. The driver side uses a held request with an accept strobe, plus a valid strobe for each read beat.

Top module: `byte_burst_bridge`

## Requirements
- R1: CPU address bits [15:2] form the word address. The half-word address sent to the driver is that word address with one bit appended below it: 0 for the low half-word (bits 15:0) and 1 for the high half-word (bits 31:16).
- R2: In burst mode (`cfg_single` = 0), every request issued to the driver carries an address with bit 0 equal to 0.
- R3: A CPU byte read returns lane n of the word, meaning bits 8n+7:8n, where n = `cpu_addr[1:0]`. In burst mode the first read beat fills bits 15:0 and the second fills bits 31:16.
- R4: In single-beat mode (`cfg_single` = 1), each word is transferred as two separate one-beat requests. The first goes to address 2w and the second to address 2w+1. For a byte write the order is: read 2w, read 2w+1, write 2w, write 2w+1.
- R5: A CPU byte write is a read-modify-write. Afterwards only the addressed lane of the word has changed, and the other three lanes keep their old values.
- R6: A burst write-back is one request at the even address. The low half-word is on `mem_wdata` in the accept cycle and the high half-word is on it in the following cycle. A request with its address and direction stays unchanged until it is accepted.
- R7: `cpu_ready` is high while the bridge is idle. It goes low in the cycle after a request is accepted. It returns high in the cycle when the read byte is valid on `cpu_rdata`, or after the last write-back beat.
- R8: A `cpu_req` pulse that arrives while `cpu_ready` is low is ignored. It causes no driver request and no change to memory.
- R9: After a synchronous reset, `cpu_ready` = 1, `mem_req` = 0 and `cpu_rdata` = 0. `cpu_rdata` changes only in a cycle where `cpu_ready` rises.
- R10: `mem_we` is 0 on every read request and 1 on every write-back request. The transfer mode is sampled when a CPU request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_single | input | 1 | 1 selects one-beat transfers, 0 selects two-beat bursts |
| cpu_req | input | 1 | One-cycle CPU access request |
| cpu_we | input | 1 | 1 for a byte write, 0 for a byte read |
| cpu_addr | input | CPU_AW | CPU byte address |
| cpu_wdata | input | LANE_W | Byte to write |
| cpu_ready | output | 1 | Idle / access complete |
| cpu_rdata | output | LANE_W | Byte read, valid when `cpu_ready` rises |
| mem_req | output | 1 | Driver request, held until accepted |
| mem_we | output | 1 | Driver request is a write |
| mem_addr | output | CPU_AW-1 | Half-word address |
| mem_wdata | output | HALF_W | Write beat data |
| mem_ack | input | 1 | Driver accepts the request |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | HALF_W | Read beat data |

## Verification
`cpu_ready` must be low at the first falling edge after the accepting edge. The bench checks that sample, then polls `cpu_ready` at falling edges within a bound. The read byte is checked in the first cycle that shows `cpu_ready` high again. Both write-back beats have reached the bench memory model by that same cycle, because the model stores the tail beat on the edge that returns ready. The model logs every accepted request, so address order, bit 0 and direction are checked per access. To show that an odd start address would swap the beats, the bench compares the model's first beat from an odd start against the high half-word.

// File: rtl/bbb_pkg.sv
package bbb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RREQ,
    ST_RDAT,
    ST_WREQ,
    ST_WTAIL
  } bbb_state_t;
endpackage

// File: rtl/bbb_addr_gen.sv
// Half-word address builder: in burst mode the start bit is forced low
// so the driver always delivers the low half-word first.
module bbb_addr_gen #(
  parameter int WORD_AW = 14
) (
  input  logic               single,
  input  logic [WORD_AW-1:0] word_addr,
  input  logic               half_sel,
  output logic [WORD_AW:0]   mem_addr
);
  logic start_bit;

  always_comb begin
    start_bit = single ? half_sel : 1'b0;
    mem_addr  = {word_addr, start_bit};
  end
endmodule

// File: rtl/bbb_word_asm.sv
// Collects read beats into a word; word_nx shows the word including the
// beat arriving this cycle, so the last beat can be used without delay.
module bbb_word_asm #(
  parameter int HALF_W = 16,
  parameter int HALVES = 2,
  localparam int HIW    = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int WORD_W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_we,
  input  logic [HIW-1:0]    beat_idx,
  input  logic [HALF_W-1:0] beat_data,
  output logic [WORD_W-1:0] word_nx
);
  genvar g;
  generate
    for (g = 0; g < HALVES; g++) begin : g_half
      logic [HALF_W-1:0] half_r;
      logic              hit;

      assign hit = beat_we && (beat_idx == HIW'(g));

      always_ff @(posedge clk) begin
        if (rst) begin
          half_r <= '0;
        end else if (hit) begin
          half_r <= beat_data;
        end
      end

      assign word_nx[g*HALF_W +: HALF_W] = hit ? beat_data : half_r;
    end
  endgenerate
endmodule

// File: rtl/bbb_lane_mux.sv
// Little-endian byte lane select and merge.
module bbb_lane_mux #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = WORD_W / LANE_W,
  localparam int LSW   = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [LSW-1:0]    lane,
  input  logic [LANE_W-1:0] new_byte,
  output logic [LANE_W-1:0] rd_byte,
  output logic [WORD_W-1:0] merged
);
  assign rd_byte = word_in[lane*LANE_W +: LANE_W];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LANE_W +: LANE_W] =
        (lane == LSW'(g)) ? new_byte : word_in[g*LANE_W +: LANE_W];
    end
  endgenerate
endmodule

// File: rtl/byte_burst_bridge.sv
module byte_burst_bridge #(
  parameter int CPU_AW = 16,
  parameter int LANE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       cfg_single,
  input  logic                                       cpu_req,
  input  logic                                       cpu_we,
  input  logic [CPU_AW-1:0]                          cpu_addr,
  input  logic [LANE_W-1:0]                          cpu_wdata,
  output logic                                       cpu_ready,
  output logic [LANE_W-1:0]                          cpu_rdata,
  output logic                                       mem_req,
  output logic                                       mem_we,
  output logic [CPU_AW-$clog2(2*HALF_W/LANE_W):0]    mem_addr,
  output logic [HALF_W-1:0]                          mem_wdata,
  input  logic                                       mem_ack,
  input  logic                                       mem_rvalid,
  input  logic [HALF_W-1:0]                          mem_rdata
);
  import bbb_pkg::*;

  localparam int WORD_W  = 2 * HALF_W;
  localparam int LANES   = WORD_W / LANE_W;
  localparam int LSW     = $clog2(LANES);
  localparam int WORD_AW = CPU_AW - LSW;

  bbb_state_t          state;
  logic [WORD_AW-1:0]  word_q;
  logic [LSW-1:0]      lane_q;
  logic [LANE_W-1:0]   wdat_q;
  logic                we_q;
  logic                single_q;
  logic                half_q;
  logic                beat_q;
  logic                ready_q;
  logic [LANE_W-1:0]   rdata_q;
  logic [WORD_W-1:0]   wword_q;

  logic                asm_we;
  logic                asm_idx;
  logic [WORD_W-1:0]   word_nx;
  logic [LANE_W-1:0]   rd_byte;
  logic [WORD_W-1:0]   merged;
  logic                wd_idx;

  assign asm_we  = (state == ST_RDAT) && mem_rvalid;
  assign asm_idx = single_q ? half_q : beat_q;

  bbb_word_asm #(.HALF_W(HALF_W), .HALVES(2)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .beat_we   (asm_we),
    .beat_idx  (asm_idx),
    .beat_data (mem_rdata),
    .word_nx   (word_nx)
  );

  bbb_lane_mux #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_lane (
    .word_in  (word_nx),
    .lane     (lane_q),
    .new_byte (wdat_q),
    .rd_byte  (rd_byte),
    .merged   (merged)
  );

  bbb_addr_gen #(.WORD_AW(WORD_AW)) u_addr (
    .single    (single_q),
    .word_addr (word_q),
    .half_sel  (half_q),
    .mem_addr  (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      word_q   <= '0;
      lane_q   <= '0;
      wdat_q   <= '0;
      we_q     <= 1'b0;
      single_q <= 1'b0;
      half_q   <= 1'b0;
      beat_q   <= 1'b0;
      ready_q  <= 1'b1;
      rdata_q  <= '0;
      wword_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cpu_req && ready_q) begin
            word_q   <= cpu_addr[CPU_AW-1:LSW];
            lane_q   <= cpu_addr[LSW-1:0];
            wdat_q   <= cpu_wdata;
            we_q     <= cpu_we;
            single_q <= cfg_single;
            half_q   <= 1'b0;
            ready_q  <= 1'b0;
            state    <= ST_RREQ;
          end
        end
        ST_RREQ: begin
          if (mem_ack) begin
            beat_q <= 1'b0;
            state  <= ST_RDAT;
          end
        end
        ST_RDAT: begin
          if (mem_rvalid) begin
            if (!single_q && !beat_q) begin
              beat_q <= 1'b1;
            end else if (single_q && !half_q) begin
              half_q <= 1'b1;
              state  <= ST_RREQ;
            end else if (we_q) begin
              wword_q <= merged;
              half_q  <= 1'b0;
              state   <= ST_WREQ;
            end else begin
              rdata_q <= rd_byte;
              ready_q <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        ST_WREQ: begin
          if (mem_ack) begin
            if (!single_q) begin
              state <= ST_WTAIL;
            end else if (!half_q) begin
              half_q <= 1'b1;
            end else begin
              ready_q <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        ST_WTAIL: begin
          ready_q <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wd_idx    = (state == ST_WTAIL) ? 1'b1 : half_q;
  assign mem_wdata = wword_q[wd_idx*HALF_W +: HALF_W];
  assign mem_req   = (state == ST_RREQ) || (state == ST_WREQ);
  assign mem_we    = (state == ST_WREQ);
  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/bbb_bridge_chk.sv
module bbb_bridge_chk #(
  parameter int LANE_W = 8,
  parameter int MEM_AW = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic [LANE_W-1:0] cpu_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              single_q,
  input logic              we_q
);
  // R2: burst requests always start on an even half-word
  p_even_start_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !single_q) |-> !mem_addr[0]);

  // R6: an unaccepted request holds address and direction
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: ready drops after an accepted request
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> !cpu_ready);

  // R8: while busy, no new request can be accepted: ready stays low while a driver request is open
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  // R9: reset state
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (cpu_ready && !mem_req));

  // R9: read data only moves when ready rises
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$rose(cpu_ready) |-> $stable(cpu_rdata));

  // R10: a read access never issues a write request
  p_read_no_we_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !we_q) |-> !mem_we);
endmodule

bind byte_burst_bridge bbb_bridge_chk #(
  .LANE_W (LANE_W),
  .MEM_AW (CPU_AW - $clog2(2*HALF_W/LANE_W) + 1)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_ready (cpu_ready),
  .cpu_rdata (cpu_rdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .single_q  (single_q),
  .we_q      (we_q)
);

// File: tb/byte_burst_bridge_bench.sv
module byte_burst_bridge_bench;
  localparam int AW   = 10;
  localparam int MAW  = AW - 1;
  localparam int NHW  = 1 << MAW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_single = 1'b0;
  logic cpu_req = 1'b0;
  logic cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [7:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [MAW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic mem_ack;
  logic mem_rvalid;
  logic [15:0] mem_rdata;

  int tests = 0;
  int fails = 0;
  int ack_dly = 0;

  always #5 clk = ~clk;

  byte_burst_bridge #(.CPU_AW(AW), .LANE_W(8), .HALF_W(16)) u_byte_burst_bridge (
    .clk(clk), .rst(rst), .cfg_single(cfg_single),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] pat(int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  // burst model: beat k of a burst starting at s reads half-word s^k
  function automatic logic [MAW-1:0] beat_addr(logic [MAW-1:0] s, int k);
    return s ^ MAW'(k);
  endfunction

  // behavioural burst memory with request log
  logic [15:0] mem [0:NHW-1];
  int ack_cnt, rd_left, rd_k, log_n;
  logic [MAW-1:0] rd_base, tail_a;
  logic tail_pend;
  logic [MAW-1:0] log_a [0:7];
  logic log_w [0:7];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NHW; i++) mem[i] <= pat(i);
      mem_ack <= 1'b0; ack_cnt <= 0; rd_left <= 0; rd_k <= 0;
      mem_rvalid <= 1'b0; mem_rdata <= '0; tail_pend <= 1'b0;
      tail_a <= '0; rd_base <= '0; log_n <= 0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (ack_cnt >= ack_dly) begin mem_ack <= 1'b1; ack_cnt <= 0; end
        else ack_cnt <= ack_cnt + 1;
      end else begin
        mem_ack <= 1'b0; ack_cnt <= 0;
      end
      if (tail_pend) begin mem[tail_a] <= mem_wdata; tail_pend <= 1'b0; end
      if (rd_left > 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[beat_addr(rd_base, rd_k)];
        rd_k <= rd_k + 1; rd_left <= rd_left - 1;
      end else begin
        mem_rvalid <= 1'b0;
      end
      if (mem_req && mem_ack) begin
        log_a[log_n & 7] <= mem_addr;
        log_w[log_n & 7] <= mem_we;
        log_n <= log_n + 1;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          if (!cfg_single) begin tail_pend <= 1'b1; tail_a <= mem_addr ^ MAW'(1); end
        end else begin
          rd_left <= cfg_single ? 1 : 2; rd_base <= mem_addr; rd_k <= 0;
        end
      end
    end
  end

  logic [15:0] sh [0:NHW-1];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input int a, input logic [7:0] wb,
                        input bit intrude, input int ia, output logic [7:0] rb, output int base);
    int n;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R7 idle ready", 32'(cpu_ready), 1);
    base = log_n;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wb;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(cpu_ready == 1'b0, "R7 ready low after accept", 32'(cpu_ready), 0);
    if (intrude) begin
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(ia); cpu_wdata = 8'hEE;
      @(negedge clk);
      cpu_req = 1'b0;
    end
    n = 0;
    while (!cpu_ready && n < 200) begin @(negedge clk); n++; end
    chk(cpu_ready == 1'b1, "R7 ready returns", 32'(cpu_ready), 1);
    rb = cpu_rdata;
  endtask

  task automatic chk_log(input int base, input logic we, input int w, input logic single);
    int per = single ? 2 : 1;
    int cnt = we ? 2 * per : per;
    chk(log_n - base == cnt, single ? "R4 request count" : "R6 request count",
        32'(log_n - base), 32'(cnt));
    for (int i = 0; i < cnt && i < 8; i++) begin
      logic [MAW-1:0] ea = MAW'(w * 2 + (single ? (i % 2) : 0));
      logic ew = we && (i >= per);
      chk(log_a[(base + i) & 7] == ea, single ? "R4 half address" : "R1 word address",
          32'(log_a[(base + i) & 7]), 32'(ea));
      chk(log_w[(base + i) & 7] == ew, "R10 request direction",
          32'(log_w[(base + i) & 7]), 32'(ew));
      if (!single)
        chk(log_a[(base + i) & 7][0] == 1'b0, "R2 even burst start",
            32'(log_a[(base + i) & 7]), 32'(ea));
    end
  endtask

  task automatic sweep(input logic single);
    logic [7:0] rb;
    int base;
    cfg_single = single;
    for (int a = 0; a < (1 << AW); a++) begin
      int w = a / 4;
      int ln = a % 4;
      logic [31:0] word = {sh[2*w+1], sh[2*w]};
      logic [7:0] eb = word[ln*8 +: 8];
      ack_dly = a % 3;
      access(1'b0, a, 8'h00, 1'b0, 0, rb, base);
      chk(rb == eb, "R3 lane read", 32'(rb), 32'(eb));
      chk_log(base, 1'b0, w, single);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      int w = a / 4;
      int ln = a % 4;
      logic [7:0] nb = 8'(a) ^ (single ? 8'h3C : 8'hC3);
      ack_dly = (a + 1) % 3;
      sh[2*w + ln/2][(ln%2)*8 +: 8] = nb;
      access(1'b1, a, nb, 1'b0, 0, rb, base);
      chk(mem[2*w] == sh[2*w], "R5 low half after merge", 32'(mem[2*w]), 32'(sh[2*w]));
      chk(mem[2*w+1] == sh[2*w+1], "R5 high half after merge", 32'(mem[2*w+1]), 32'(sh[2*w+1]));
      chk_log(base, 1'b1, w, single);
    end
  endtask

  initial begin
    logic [7:0] rb;
    int base, keep;
    for (int i = 0; i < NHW; i++) sh[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R9 reset ready", 32'(cpu_ready), 1);
    chk(mem_req == 1'b0, "R9 reset mem_req", 32'(mem_req), 0);
    chk(cpu_rdata == 8'h00, "R9 reset rdata", 32'(cpu_rdata), 0);
    rst = 1'b0;

    // model: an odd start would deliver the high half first
    chk(mem[beat_addr(MAW'(5), 0)] == sh[5], "R2 odd start swaps beats",
        32'(mem[beat_addr(MAW'(5), 0)]), 32'(sh[5]));
    chk(mem[beat_addr(MAW'(4), 0)] == sh[4], "R3 even start low first",
        32'(mem[beat_addr(MAW'(4), 0)]), 32'(sh[4]));

    sweep(1'b0);

    // R8: a write pulse while busy is ignored
    ack_dly = 2;
    access(1'b0, 37, 8'h00, 1'b1, 200, rb, base);
    chk(rb == 8'({sh[19], sh[18]} >> 8), "R8 read unaffected", 32'(rb), 32'({sh[19], sh[18]} >> 8));
    chk(log_n - base == 1, "R8 no extra request", 32'(log_n - base), 1);
    keep = log_n;
    repeat (10) @(negedge clk);
    chk(log_n == keep, "R8 no late request", 32'(log_n), 32'(keep));
    chk(mem[100] == sh[100], "R8 memory untouched", 32'(mem[100]), 32'(sh[100]));

    sweep(1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule